// File: doc/BRIEF.md
# Quad Wiper Register Controller with Two-Wire Serial Slave

This block is a slave on a two-wire serial bus (I2C) that owns four 8-bit volatile wiper registers. A bus master selects one register with an address byte and then either writes one new value into it or reads registers back one after another. All four register values leave the block in parallel on one packed bus so that resistor-ladder decode logic downstream can use them at any time.

The bus inputs reach the block already synchronised to the system clock. The block finds SCL edges, START and STOP conditions, and the SDA value from these sampled levels. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data. The two strap inputs set the low bits of the identification byte, so up to four of these blocks can share one bus.

Top module: `quad_wiper_i2c`

## Requirements
- R1: After reset all four wiper registers hold 80h, so `wiperBus` is 80808080h, and `sdaOe` is 0 (SDA released).
- R2: An identification byte is acknowledged only when bits 7..3 are 01010 and bits 2..1 equal `strapA[1:0]`. Bit 0 selects the direction: 0 means write and 1 means read. The slave acknowledges by pulling SDA low for the ninth SCL clock.
- R3: If the identification byte does not match, the slave does not acknowledge it. Until the next START it acknowledges nothing and changes no register.
- R4: A write is START, a matching identification byte with bit 0 at 0, an address byte, one data byte and STOP. The slave acknowledges all three bytes and loads the data into the addressed register. The other registers keep their values.
- R5: Address 00h, 01h, 02h and 03h select wiper 0, 1, 2 and 3; wiper n occupies `wiperBus[8n+7:8n]`. An address above 03h gets no acknowledge, and the data byte that follows it gets none and changes no register.
- R6: A read is START, identification (write), address, repeated START, identification (read). The slave acknowledges all three bytes. It then sends the addressed register MSB first and changes SDA only while SCL is low.
- R7: After each data byte the read pointer steps by one and wraps from 03h to 00h. Sending continues while the master acknowledges. After a master NACK, SDA stays released.
- R8: A register changes only at the ninth SCL rising edge of a complete data byte. A STOP or START inside the byte leaves every register unchanged.
- R9: Bus activity before the first START, including a byte that would otherwise match, is ignored and gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level |
| strapA | input | 2 | Address strap bits, compared with identification bits 2..1 |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| wiperBus | output | 32 | Wiper n at bits 8n+7..8n |

## Verification
Writes use a different value for each wiper (00h, FFh and alternating patterns) so that a wrong address decode shows up as a value in the wrong lane. Identification bytes with a wrong prefix and with a wrong strap field are kept apart, and a strap change shows that the match follows the pins rather than a constant. A read burst starts at pointer 2 and runs past the wrap, so an increment or wrap error changes the sequence of bytes. In the aborted-write cases the bench interrupts the data byte with a STOP in one case and a repeated START in the other. It also compares the registers just before and just after the ninth clock, which shows exactly when the write takes effect.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDATA,
    ST_READ
  } busState_t;

  typedef struct packed {
    logic shiftRx;
    logic loadTx;
    logic shiftTx;
    logic setPtr;
    logic incPtr;
    logic writeReg;
  } dpStrobe_t;
endpackage

// File: rtl/wiper_bus_ctrl.sv
module wiper_bus_ctrl
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS = 4,
  parameter logic [4:0] ID_PREFIX = 5'b01010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapA,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output logic              sdaOe,
  output dpStrobe_t         strb
);
  localparam logic [BYTE_W-1:0] WIPER_CNT = BYTE_W'(NUM_WIPERS);

  logic      sclPrev, sdaPrev;
  busState_t state;
  logic [3:0] bitCnt;
  logic      ackDrive, txEn, masterAck;

  logic sclRise, sclFall, startCond, stopCond;
  logic idMatch, addrOk, rxState;

  assign sclRise   = sclIn & ~sclPrev;
  assign sclFall   = ~sclIn & sclPrev;
  assign startCond = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopCond  = sclIn & sclPrev & ~sdaPrev & sdaIn;

  assign idMatch = (rxByte[7:3] == ID_PREFIX) && (rxByte[2:1] == strapA);
  assign addrOk  = rxByte < WIPER_CNT;
  assign rxState = (state == ST_ID) || (state == ST_ADDR) || (state == ST_WDATA);

  // datapath strobes
  always_comb begin
    strb = '0;
    strb.shiftRx  = sclRise && rxState && (bitCnt < 4'd8);
    strb.setPtr   = sclRise && (bitCnt == 4'd8) && (state == ST_ADDR) && ackDrive;
    strb.writeReg = sclRise && (bitCnt == 4'd8) && (state == ST_WDATA) && ackDrive;
    strb.incPtr   = sclRise && (bitCnt == 4'd8) && (state == ST_READ);
    strb.shiftTx  = sclFall && (state == ST_READ) && (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    strb.loadTx   = sclFall && (bitCnt == 4'd9) &&
                    (((state == ST_ID) && ackDrive && rxByte[0]) ||
                     ((state == ST_READ) && masterAck));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txEn      <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (startCond) begin
        state     <= ST_ID;
        bitCnt    <= '0;
        ackDrive  <= 1'b0;
        txEn      <= 1'b0;
        masterAck <= 1'b0;
      end else if (stopCond) begin
        state    <= ST_IDLE;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txEn     <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
          if ((bitCnt == 4'd8) && (state == ST_READ)) masterAck <= ~sdaIn;
        end
        if (sclFall) begin
          if ((bitCnt == 4'd8) && rxState) begin
            unique case (state)
              ST_ID:   ackDrive <= idMatch;
              ST_ADDR: ackDrive <= addrOk;
              default: ackDrive <= 1'b1;
            endcase
          end
          if ((bitCnt == 4'd8) && (state == ST_READ)) txEn <= 1'b0;
          if (bitCnt == 4'd9) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            unique case (state)
              ST_ID: begin
                if (!ackDrive) state <= ST_IDLE;
                else if (rxByte[0]) begin
                  state <= ST_READ;
                  txEn  <= 1'b1;
                end else state <= ST_ADDR;
              end
              ST_ADDR:  state <= ackDrive ? ST_WDATA : ST_IDLE;
              ST_READ: begin
                if (masterAck) txEn <= 1'b1;
                else state <= ST_IDLE;
              end
              default:  state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign sdaOe = ackDrive | (txEn & ~txMsb);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R3
  AST_ACK_NINTH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> (bitCnt >= 4'd8)); // R2
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclIn)); // R6
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> (state == ST_ID) && (bitCnt == 4'd0)); // R9
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS = 4,
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'h80
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sdaIn,
  input  dpStrobe_t                    strb,
  output logic [BYTE_W-1:0]            rxByte,
  output logic                         txMsb,
  output logic [NUM_WIPERS*BYTE_W-1:0] wiperBus
);
  localparam int PTR_W = $clog2(NUM_WIPERS);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_WIPERS - 1);

  logic [BYTE_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] wiperReg [NUM_WIPERS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (strb.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      if (strb.loadTx) txShift <= wiperReg[ptr];
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.setPtr) ptr <= rxShift[PTR_W-1:0];
      else if (strb.incPtr) ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : gWiper
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wiperReg[g] <= RESET_VAL;
      else if (strb.writeReg && (ptr == PTR_W'(g))) wiperReg[g] <= rxShift;
    end
    assign wiperBus[g*BYTE_W +: BYTE_W] = wiperReg[g];
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[BYTE_W-1];

  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeReg |=> $stable(wiperBus)); // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.setPtr && (ptr == LAST_PTR)) |=> (ptr == '0)); // R7
  AST_ONE_STROBE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.setPtr, strb.writeReg, strb.incPtr}) <= 1); // R5
endmodule

// File: rtl/quad_wiper_i2c.sv
module quad_wiper_i2c
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS = 4,
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'h80,
  parameter logic [4:0] ID_PREFIX = 5'b01010
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  input  logic [1:0]                   strapA,
  output logic                         sdaOe,
  output logic [NUM_WIPERS*BYTE_W-1:0] wiperBus
);
  dpStrobe_t         strb;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;

  wiper_bus_ctrl #(.NUM_WIPERS(NUM_WIPERS), .ID_PREFIX(ID_PREFIX)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapA(strapA),
    .rxByte(rxByte), .txMsb(txMsb), .sdaOe(sdaOe), .strb(strb)
  );

  wiper_datapath #(.NUM_WIPERS(NUM_WIPERS), .RESET_VAL(RESET_VAL)) uData (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strb(strb),
    .rxByte(rxByte), .txMsb(txMsb), .wiperBus(wiperBus)
  );
endmodule

// File: tb/quad_wiper_i2c_test.sv
module quad_wiper_i2c_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        sdaM = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        sdaOe;
  logic [31:0] wiperBus;
  logic        sdaLine;
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 0;
  logic [7:0]  expW [4];

  assign sdaLine = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  quad_wiper_i2c uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .strapA(strap),
    .sdaOe(sdaOe), .wiperBus(wiperBus)
  );

  function automatic logic [31:0] expBus();
    return {expW[3], expW[2], expW[1], expW[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; q(); scl = 1'b1; q(); sdaM = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic busStop();
    sdaM = 1'b0; q(); scl = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic sendBit(logic b);
    sdaM = b; q(); scl = 1'b1; q(); scl = 1'b0; q();
  endtask

  task automatic ackClock(output logic ackSeen);
    sdaM = 1'b1; q(); scl = 1'b1; q(); ackSeen = ~sdaLine; scl = 1'b0; q();
  endtask

  task automatic sendByte(logic [7:0] b, output logic ackSeen);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackClock(ackSeen);
  endtask

  task automatic readByte(logic giveAck, output logic [7:0] data, output logic steady);
    logic s1, s2;
    sdaM = 1'b1;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1;
      repeat (2) @(negedge clk); s1 = sdaLine;
      repeat (2) @(negedge clk); s2 = sdaLine;
      data[i] = s1;
      if (s1 !== s2) steady = 1'b0;
      scl = 1'b0;
    end
    q(); sdaM = giveAck ? 1'b0 : 1'b1;
    q(); scl = 1'b1; q(); scl = 1'b0; q(); sdaM = 1'b1;
  endtask

  task automatic doWrite(logic [7:0] idB, logic [7:0] addr, logic [7:0] data,
                         output logic a1, output logic a2, output logic a3);
    busStart();
    sendByte(idB, a1);
    sendByte(addr, a2);
    sendByte(data, a3);
    busStop();
  endtask

  task automatic testReset();
    check("R1", wiperBus, 32'h80808080, "reset wipers");
    check("R1", {31'b0, sdaOe}, 32'h0, "reset sda released");
  endtask

  task automatic testNoStart();
    logic a;
    scl = 1'b0; q();
    sendByte(8'h54, a);
    check("R9", {31'b0, a}, 32'h0, "id before start acked");
    sendByte(8'h00, a);
    sendByte(8'h33, a);
    check("R9", {31'b0, a}, 32'h0, "data before start acked");
    busStop();
    check("R9", wiperBus, expBus(), "wipers after pre-start traffic");
  endtask

  task automatic testWrite();
    logic a1, a2, a3;
    logic [7:0] vals [4] = '{8'h3C, 8'hFF, 8'h00, 8'hA5};
    for (int i = 0; i < 4; i++) begin
      doWrite(8'h54, 8'(i), vals[i], a1, a2, a3);
      expW[i] = vals[i];
      check("R2", {31'b0, a1}, 32'h1, "id write ack");
      check("R5", {31'b0, a2}, 32'h1, "valid address ack");
      check("R4", {31'b0, a3}, 32'h1, "data ack");
      check("R4", wiperBus, expBus(), "wipers after write");
    end
  endtask

  task automatic testBadId();
    logic a1, a2, a3;
    doWrite(8'h52, 8'h01, 8'h77, a1, a2, a3);
    check("R3", {29'b0, a1, a2, a3}, 32'h0, "wrong strap acks");
    check("R3", wiperBus, expBus(), "wipers after wrong strap");
    doWrite(8'h74, 8'h02, 8'h66, a1, a2, a3);
    check("R3", {29'b0, a1, a2, a3}, 32'h0, "wrong prefix acks");
    check("R3", wiperBus, expBus(), "wipers after wrong prefix");
  endtask

  task automatic testBadAddr();
    logic a1, a2, a3;
    doWrite(8'h54, 8'h04, 8'h99, a1, a2, a3);
    check("R5", {29'b0, a1, a2, a3}, 32'h4, "addr 04h ack pattern");
    check("R5", wiperBus, expBus(), "wipers after addr 04h");
    doWrite(8'h54, 8'hFF, 8'h12, a1, a2, a3);
    check("R5", {29'b0, a1, a2, a3}, 32'h4, "addr FFh ack pattern");
    check("R5", wiperBus, expBus(), "wipers after addr FFh");
  endtask

  task automatic testRead();
    logic a1, a2, a3, st;
    logic [7:0] d;
    busStart();
    sendByte(8'h54, a1);
    sendByte(8'h02, a2);
    busStart();
    sendByte(8'h55, a3);
    check("R6", {29'b0, a1, a2, a3}, 32'h7, "read preamble acks");
    for (int k = 0; k < 6; k++) begin
      readByte(k != 5, d, st);
      check("R7", {24'b0, d}, {24'b0, expW[(2 + k) % 4]}, "read sequence byte");
      check("R6", {31'b0, st}, 32'h1, "sda steady while scl high");
    end
    check("R7", {31'b0, sdaOe}, 32'h0, "released after nack");
    busStop();
    check("R7", wiperBus, expBus(), "read leaves wipers");
  endtask

  task automatic testAbort();
    logic a1, a2, a;
    busStart(); sendByte(8'h54, a1); sendByte(8'h01, a2);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    check("R8", wiperBus, expBus(), "stop mid byte");
    busStart(); sendByte(8'h54, a1); sendByte(8'h00, a2);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    busStart(); busStop();
    check("R8", wiperBus, expBus(), "start mid byte");
    busStart(); sendByte(8'h54, a1); sendByte(8'h03, a2);
    for (int i = 7; i >= 0; i--) sendBit(8'h5E >> i);
    check("R8", wiperBus, expBus(), "before ninth clock");
    ackClock(a);
    expW[3] = 8'h5E;
    check("R8", wiperBus, expBus(), "after ninth clock");
    busStop();
  endtask

  task automatic testStrap();
    logic a1, a2, a3;
    strap = 2'b01; q();
    doWrite(8'h52, 8'h02, 8'hC7, a1, a2, a3);
    expW[2] = 8'hC7;
    check("R2", {29'b0, a1, a2, a3}, 32'h7, "new strap acks");
    check("R2", wiperBus, expBus(), "write under new strap");
    doWrite(8'h54, 8'h02, 8'h01, a1, a2, a3);
    check("R2", {29'b0, a1, a2, a3}, 32'h0, "old strap rejected");
    check("R2", wiperBus, expBus(), "wipers after old strap");
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) expW[i] = 8'h80;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    q();
    testReset();
    testNoStart();
    testWrite();
    testBadId();
    testBadAddr();
    testRead();
    testAbort();
    testStrap();
    done = 1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end
endmodule